// File: doc/BRIEF.md
# Authentication Status and Result Readout Shifter

This block is the slave-side response path for the authentication status read on a serial peripheral interface. The host lowers chip select, sends the read opcode (96h) and one dummy byte. The block then shifts out the status byte, a 96-bit tag, a 32-bit counter value and a 256-bit signature. Every field goes out most significant bit first, and one bit changes on each falling serial clock edge. The execution logic supplies all four fields as parallel inputs. The block captures them at the moment the status byte is launched, so the stream cannot change partway through a transfer.

Bit 0 of the status byte is the busy flag, and it is sampled at that same launch edge. When the flag is set, the result fields are not sent. Instead the captured status byte repeats on every byte until chip select rises. The host may end a read at any byte or bit by raising chip select, and the next falling chip select starts a new decode from the opcode.

The serial pins are oversampled by the core clock through a synchronizer of `SYNC_STAGES` flops. The output changes within `SYNC_STAGES + 1` core cycles of a falling serial clock edge. The serial half-period must therefore exceed that delay by the host's setup margin. The results are plain parallel inputs, not a stream, so the block has no back-pressure: the host sets the pace, and the fields only have to be stable when the status byte is launched.

Top module: `auth_status_readout`

## Requirements
- R1: While chip select (`spi_cs_n`) is high, `spi_miso_en` is 0 without waiting for the core clock. Whenever `spi_miso_en` is 0, `spi_miso` is 0.
- R2: `spi_miso_en` stays 0 during the 16 opcode and dummy bits. It rises with status bit 7, which is launched by the falling edge that follows the 16th rising edge.
- R3: After the lead bits, the stream is status (8 bits), tag (96), counter (32) and signature (256), in that order, each MSB first. Exactly one bit is sent per falling edge.
- R4: The busy flag is status bit 0, sampled at launch. When it is 1, every output byte from the status byte onward equals the captured status byte.
- R5: Status, tag, counter and signature are captured at launch. Changes to these inputs afterwards do not alter the bytes sent in that transfer.
- R6: The opcode is received MSB first on `spi_mosi` and sampled on rising edges. If it is not 96h, `spi_miso_en` stays 0 for the whole transfer.
- R7: Raising chip select at any bit, including in the middle of a byte, abandons the transfer. The next transfer decodes from its first bit and streams correctly.
- R8: After the 49 payload bytes, the output stays enabled and sends 0 bits.
- R9: Both idle clock levels are accepted. A falling edge before the first rising edge of a transfer has no effect.
- R10: During and after reset, before any transfer, `spi_miso_en` and `spi_miso` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Host-to-device serial data |
| rsp_status | input | 8 | Status byte; bit 0 is busy |
| rsp_tag | input | 96 | Tag field of the last counter read |
| rsp_ctr | input | 32 | Counter field of the last counter read |
| rsp_sig | input | 256 | Signature field of the last counter read |
| spi_miso | output | 1 | Device-to-host serial data |
| spi_miso_en | output | 1 | Output enable for the data pad; 0 means high impedance |

## Verification
A rising-edge counter that is off by one moves every field by one bit. This shows up as a wrong status byte on the very first output byte, or as the enable rising one serial bit early or late. A busy latch that takes the wrong bit, or that fails to hold, shows on the second output byte. At that point a busy read repeats the tag's first byte instead of the status, or a ready read repeats the status. Stale state left by an aborted transfer shows on the first byte of the next transfer, as an enable that never rises or a misaligned status.

// File: rtl/auth_rd_pkg.sv
package auth_rd_pkg;

  // Decode phase of one chip-select window
  typedef enum logic [1:0] {
    PH_LEAD   = 2'd0,  // opcode and dummy bits still arriving
    PH_STREAM = 2'd1,  // response bits are being launched
    PH_MUTE   = 2'd2   // opcode not ours, stay off the line
  } rd_phase_e;

endpackage

// File: rtl/auth_rd_pin_sync.sv
module auth_rd_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sel_o,
  output logic rise_o,
  output logic fall_o,
  output logic mosi_o
);

  // One extra stage on the clock gives the previous level for edge detect
  logic [STAGES:0]   sclk_q;
  logic [STAGES-1:0] cs_q;
  logic [STAGES-1:0] mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[STAGES-1:0], sclk_i};
      cs_q   <= {cs_q[STAGES-2:0], cs_n_i};
      mosi_q <= {mosi_q[STAGES-2:0], mosi_i};
    end
  end

  assign rise_o = sclk_q[STAGES-1] & ~sclk_q[STAGES];
  assign fall_o = ~sclk_q[STAGES-1] & sclk_q[STAGES];
  assign sel_o  = ~cs_q[STAGES-1];
  assign mosi_o = mosi_q[STAGES-1];

endmodule

// File: rtl/auth_rd_lead_decoder.sv
module auth_rd_lead_decoder
  import auth_rd_pkg::*;
#(
  parameter int             OP_W      = 8,
  parameter logic [OP_W-1:0] OPCODE   = 8'h96,
  parameter int             LEAD_BITS = 16,
  parameter int             CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             mosi_i,
  output logic [CNT_W-1:0] rise_cnt_o,
  output logic             op_hit_o,
  output logic             launch_o,
  output logic             shift_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [OP_W-1:0]  op_q;
  rd_phase_e        ph_q;

  assign rise_cnt_o = cnt_q;
  assign op_hit_o   = (cnt_q >= CNT_W'(OP_W)) && (op_q == OPCODE);
  // The first falling edge after the last lead bit launches status bit 7
  assign launch_o   = (ph_q == PH_LEAD) && fall_i &&
                      (cnt_q == CNT_W'(LEAD_BITS)) && op_hit_o;
  assign shift_o    = (ph_q == PH_STREAM) && fall_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      op_q  <= '0;
      ph_q  <= PH_LEAD;
    end else if (!sel_i) begin
      cnt_q <= '0;
      op_q  <= '0;
      ph_q  <= PH_LEAD;
    end else begin
      if (rise_i && (cnt_q != CNT_W'(LEAD_BITS)))
        cnt_q <= cnt_q + 1'b1;
      if (rise_i && (cnt_q < CNT_W'(OP_W)))
        op_q <= {op_q[OP_W-2:0], mosi_i};
      if (launch_o)
        ph_q <= PH_STREAM;
      else if ((ph_q == PH_LEAD) && (cnt_q >= CNT_W'(OP_W)) && !op_hit_o)
        ph_q <= PH_MUTE;
    end
  end

endmodule

// File: rtl/auth_rd_resp_shifter.sv
module auth_rd_resp_shifter #(
  parameter int STAT_W   = 8,
  parameter int TAG_W    = 96,
  parameter int CTR_W    = 32,
  parameter int SIG_W    = 256,
  parameter int BUSY_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              launch_i,
  input  logic              shift_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [CTR_W-1:0]  ctr_i,
  input  logic [SIG_W-1:0]  sig_i,
  output logic              bit_o,
  output logic              drive_o,
  output logic              busy_o
);

  localparam int PAY_W = STAT_W + TAG_W + CTR_W + SIG_W;

  logic [PAY_W-1:0] frame_q;
  logic             drive_q;
  logic             busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      drive_q <= 1'b0;
      busy_q  <= 1'b0;
    end else if (!sel_i) begin
      frame_q <= '0;
      drive_q <= 1'b0;
      busy_q  <= 1'b0;
    end else if (launch_i) begin
      frame_q <= {status_i, tag_i, ctr_i, sig_i};
      drive_q <= 1'b1;
      busy_q  <= status_i[BUSY_BIT];
    end else if (shift_i) begin
      if (busy_q)
        // Busy: the status byte circulates in the top of the frame
        frame_q[PAY_W-1 -: STAT_W] <= {frame_q[PAY_W-2 -: STAT_W-1],
                                       frame_q[PAY_W-1]};
      else
        // Ready: plain shift, zeros follow the payload
        frame_q <= {frame_q[PAY_W-2:0], 1'b0};
    end
  end

  assign bit_o   = frame_q[PAY_W-1];
  assign drive_o = drive_q;
  assign busy_o  = busy_q;

endmodule

// File: rtl/auth_status_readout.sv
module auth_status_readout #(
  parameter logic [7:0] OPCODE      = 8'h96,
  parameter int         DUMMY_BYTES = 1,
  parameter int         STAT_W      = 8,
  parameter int         TAG_W       = 96,
  parameter int         CTR_W       = 32,
  parameter int         SIG_W       = 256,
  parameter int         BUSY_BIT    = 0,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic [STAT_W-1:0] rsp_status,
  input  logic [TAG_W-1:0]  rsp_tag,
  input  logic [CTR_W-1:0]  rsp_ctr,
  input  logic [SIG_W-1:0]  rsp_sig,
  output logic              spi_miso,
  output logic              spi_miso_en
);

  localparam int OP_W      = 8;
  localparam int LEAD_BITS = OP_W * (1 + DUMMY_BYTES);
  localparam int CNT_W     = $clog2(LEAD_BITS + 1);

  logic             sel;
  logic             rise;
  logic             fall;
  logic             mosi_s;
  logic [CNT_W-1:0] rise_cnt;
  logic             op_hit;
  logic             launch;
  logic             shift;
  logic             frame_bit;
  logic             drive;
  logic             busy;

  auth_rd_pin_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_i (spi_sclk),
    .cs_n_i (spi_cs_n),
    .mosi_i (spi_mosi),
    .sel_o  (sel),
    .rise_o (rise),
    .fall_o (fall),
    .mosi_o (mosi_s)
  );

  auth_rd_lead_decoder #(
    .OP_W      (OP_W),
    .OPCODE    (OPCODE),
    .LEAD_BITS (LEAD_BITS),
    .CNT_W     (CNT_W)
  ) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (sel),
    .rise_i     (rise),
    .fall_i     (fall),
    .mosi_i     (mosi_s),
    .rise_cnt_o (rise_cnt),
    .op_hit_o   (op_hit),
    .launch_o   (launch),
    .shift_o    (shift)
  );

  auth_rd_resp_shifter #(
    .STAT_W   (STAT_W),
    .TAG_W    (TAG_W),
    .CTR_W    (CTR_W),
    .SIG_W    (SIG_W),
    .BUSY_BIT (BUSY_BIT)
  ) u_shf (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_i    (sel),
    .launch_i (launch),
    .shift_i  (shift),
    .status_i (rsp_status),
    .tag_i    (rsp_tag),
    .ctr_i    (rsp_ctr),
    .sig_i    (rsp_sig),
    .bit_o    (frame_bit),
    .drive_o  (drive),
    .busy_o   (busy)
  );

  // Raw chip select gates the pad so release does not wait on the synchronizer
  assign spi_miso_en = drive & ~spi_cs_n;
  assign spi_miso    = spi_miso_en & frame_bit;

endmodule

// File: rtl/auth_status_readout_chk.sv
module auth_status_readout_chk #(
  parameter int CNT_W     = 5,
  parameter int OP_W      = 8,
  parameter int LEAD_BITS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel,
  input logic [CNT_W-1:0] rise_cnt,
  input logic             op_hit,
  input logic             launch,
  input logic             shift,
  input logic             drive,
  input logic             busy,
  input logic             frame_bit
);

  // R2: the line is taken only once all lead bits have been counted
  a_r2_enable_after_lead: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive) |-> (rise_cnt == CNT_W'(LEAD_BITS)) && op_hit);

  // R2: a launch decision always takes the line on the next cycle
  a_r2_launch_drives: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> drive);

  // R4: the busy mode chosen at launch holds for the rest of the transfer
  a_r4_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    drive && $past(drive) |-> $stable(busy));

  // R3: the output bit moves only on a falling serial edge
  a_r3_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    drive && $past(drive) && !$past(shift) |-> $stable(frame_bit));

  // R6: a foreign opcode never reaches the driving state
  a_r6_foreign_mute: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_cnt >= CNT_W'(OP_W)) && !op_hit |-> !drive);

  // R7: deselection always clears the driving state
  a_r7_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !drive);

endmodule

bind auth_status_readout auth_status_readout_chk #(
  .CNT_W     (CNT_W),
  .OP_W      (OP_W),
  .LEAD_BITS (LEAD_BITS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel       (sel),
  .rise_cnt  (rise_cnt),
  .op_hit    (op_hit),
  .launch    (launch),
  .shift     (shift),
  .drive     (drive),
  .busy      (busy),
  .frame_bit (frame_bit)
);

// File: tb/test_auth_status_readout.sv
`timescale 1ns/1ps
module test_auth_status_readout;

  localparam int H = 32;  // serial half period, multiple of the 4 ns clock

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         spi_sclk = 1'b0;
  logic         spi_cs_n = 1'b1;
  logic         spi_mosi = 1'b0;
  logic [7:0]   rsp_status = '0;
  logic [95:0]  rsp_tag = '0;
  logic [31:0]  rsp_ctr = '0;
  logic [255:0] rsp_sig = '0;
  logic         spi_miso;
  logic         spi_miso_en;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  auth_status_readout i_auth_status_readout (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_sclk    (spi_sclk),
    .spi_cs_n    (spi_cs_n),
    .spi_mosi    (spi_mosi),
    .rsp_status  (rsp_status),
    .rsp_tag     (rsp_tag),
    .rsp_ctr     (rsp_ctr),
    .rsp_sig     (rsp_sig),
    .spi_miso    (spi_miso),
    .spi_miso_en (spi_miso_en)
  );

  // {opcode, status, bytes read after the dummy byte}
  localparam logic [23:0] VECS [7] = '{
    {8'h96, 8'h80, 8'd49},
    {8'h96, 8'h80, 8'd3},
    {8'h96, 8'h01, 8'd6},
    {8'h96, 8'h84, 8'd52},
    {8'h95, 8'h80, 8'd4},
    {8'h96, 8'h03, 8'd5},
    {8'h69, 8'h01, 8'd3}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [383:0] mk(input int s);
    logic [383:0] r;
    for (int i = 0; i < 48; i++) r[8*i +: 8] = 8'(s * 37 + i * 11 + 5);
    return r;
  endfunction

  task automatic load(input logic [7:0] st, input int seed);
    rsp_status = st;
    {rsp_tag, rsp_ctr, rsp_sig} = mk(seed);
  endtask

  // One read transfer; expected values taken from the inputs before launch
  task automatic xfer(input logic [7:0] op, input int nby, input bit m3,
                      input int abort_at, input int mut_at, input string lbl);
    logic [7:0]   exp_st = rsp_status;
    logic [383:0] exp_pl = {rsp_tag, rsp_ctr, rsp_sig};
    bit           busy   = exp_st[0];
    bit           hit    = (op == 8'h96);
    bit           any_en = 1'b0;
    logic [7:0]   acc    = '0;
    logic [7:0]   exp_b;
    string        req;
    int           total  = 16 + 8 * nby;
    int           k;
    spi_sclk = m3;
    #(H);
    spi_cs_n = 1'b0;
    #(H);
    for (int b = 0; b < total; b++) begin
      if (abort_at >= 0 && b == abort_at) break;
      if (b == mut_at) begin
        rsp_status = ~rsp_status;
        rsp_tag    = ~rsp_tag;
        rsp_ctr    = ~rsp_ctr;
      end
      spi_sclk = 1'b0;
      spi_mosi = (b < 8) ? op[7-b] : 1'b0;
      #(H);
      if (hit && b == 15)
        chk(spi_miso_en == 1'b0, "R2", "enable during dummy", 32'(spi_miso_en), 0);
      if (hit && b == 16)
        chk(spi_miso_en == 1'b1, "R2", "enable at status bit 7", 32'(spi_miso_en), 1);
      if (!hit && spi_miso_en) any_en = 1'b1;
      if (hit && b >= 16) begin
        acc = {acc[6:0], spi_miso};
        if (((b - 16) % 8) == 7) begin
          k = (b - 16) / 8;
          if (busy || k == 0) exp_b = exp_st;
          else if (k <= 48)   exp_b = exp_pl[383 - 8*(k-1) -: 8];
          else                exp_b = 8'h00;
          if (lbl != "")        req = lbl;
          else if (k > 48)      req = "R8";
          else if (busy)        req = "R4";
          else if (m3)          req = "R9";
          else                  req = "R3";
          chk(acc == exp_b, req, $sformatf("byte %0d", k), 32'(acc), 32'(exp_b));
        end
      end
      spi_sclk = 1'b1;
      #(H);
    end
    spi_cs_n = 1'b1;
    #1;
    chk(spi_miso_en == 1'b0, "R1", "enable after deselect", 32'(spi_miso_en), 0);
    chk(spi_miso == 1'b0, "R1", "data after deselect", 32'(spi_miso), 0);
    if (!m3) spi_sclk = 1'b0;
    if (!hit) chk(!any_en, "R6", "enable with foreign opcode", 32'(any_en), 0);
    #(2*H - 1);
  endtask

  initial begin : watchdog
    #(150000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    #20;
    chk(spi_miso_en == 1'b0, "R10", "enable in reset", 32'(spi_miso_en), 0);
    chk(spi_miso == 1'b0, "R10", "data in reset", 32'(spi_miso), 0);
    rst_n = 1'b1;
    #40;
    chk(spi_miso_en == 1'b0, "R10", "enable after reset", 32'(spi_miso_en), 0);
    chk(spi_miso == 1'b0, "R10", "data after reset", 32'(spi_miso), 0);

    for (int i = 0; i < 7; i++) begin
      load(VECS[i][15:8], i);
      xfer(VECS[i][23:16], int'(VECS[i][7:0]), i[0], -1, -1, "");
    end

    // R7: abort in the middle of a tag byte, then a clean full read
    load(8'h80, 11);
    xfer(8'h96, 10, 1'b0, 27, -1, "R7");
    load(8'h80, 12);
    xfer(8'h96, 10, 1'b0, -1, -1, "R7");
    // R7: abort inside the opcode, then a read in idle-high clock mode
    xfer(8'h96, 4, 1'b1, 5, -1, "R7");
    load(8'h40, 13);
    xfer(8'h96, 4, 1'b1, -1, -1, "R7");

    // R5: inputs change after launch, ready and busy cases
    load(8'h80, 14);
    xfer(8'h96, 14, 1'b0, -1, 20, "R5");
    load(8'h81, 15);
    xfer(8'h96, 4, 1'b0, -1, 20, "R5");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule